// File: doc/BRIEF.md
# Indexed Set/Clear Interrupt Mask Controller

This block arbitrates among 64 interrupt request lines. Each source has a mask bit and a byte-wide control register whose low three bits give its priority level. Software never rewrites a whole mask word. To mask one source it writes that source's number to a mask-set register, and to unmask it it writes the number to a mask-clear register. One reserved code applied to either register masks or unmasks every source in a single access.

On every clock the block registers the winner among the pending, unmasked sources: a valid flag, the winning source number and its level. Cascading several units and building processor vectors are left to the surrounding logic. The winner output is a plain status bus refreshed every cycle, so it has no handshake and cannot be back-pressured. A consumer simply samples it when it needs it. The register bus is a simple single-cycle write port and a read port with one cycle of latency.

Address map: 0x00 to 0x3F select the control register of source 0 to 63, 0x40 is mask-set and 0x41 is mask-clear. Writes to 0x42 to 0x7F have no effect.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every control register is 0, and `win_valid`, `win_idx` and `win_level` are 0.
- R2: Writing a value k with k < 0x40 to address 0x40 sets mask bit k, which masks source k.
- R3: Writing a value k with k < 0x40 to address 0x41 clears mask bit k, which unmasks source k.
- R4: Writing 0xFF to address 0x40 sets all 64 mask bits in one access.
- R5: Writing 0xFF to address 0x41 clears all 64 mask bits in one access.
- R6: Writing a value from 0x40 to 0xFE to address 0x40 or 0x41 leaves every mask bit unchanged. Writes to addresses 0x42 to 0x7F change no state.
- R7: A write to address k < 0x40 stores the full byte in the control register of source k, and bits [2:0] of that byte are its level. A read issued on a cycle returns that byte on `bus_rdata` after the next rising edge. A read of any address at or above 0x40 returns 0.
- R8: A pending unmasked source whose level is 0 never wins. When no source qualifies, `win_valid` is 0 and `win_idx` and `win_level` are 0.
- R9: Among the sources whose request is high, whose mask bit is 0 and whose level is nonzero, the highest level wins. On a tie in level, the lowest source number wins.
- R10: The outputs are registered. At each rising edge they take the result for the requests present at that edge and for the mask and levels held before that edge. A register write therefore shows at the outputs one edge later than a request change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Register read strobe |
| bus_raddr | input | 7 | Read address |
| bus_rdata | output | 8 | Read data, one cycle after `bus_re` |
| irq_req | input | 64 | Request lines, one per source |
| win_valid | output | 1 | A qualifying source exists |
| win_idx | output | 6 | Number of the winning source |
| win_level | output | 3 | Level of the winning source |

## Verification
A mask bit held in the wrong state makes a source win while software believes it is masked, or keeps a source silent. Either shows on `win_valid`/`win_idx` on the first cycle after that source requests, and the bench requests each source densely and at random so that such a fault surfaces quickly. A corrupted control byte shows at once on a read-back, and it also shows as a wrong winner or a wrong `win_level` in the first contest that involves that source. A wrong tie-break or level compare appears in any cycle where two qualifying sources collide. Directed equal-level and level-zero cases force such cycles, and they do not wait for the random traffic to produce them.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC  = 64;
  localparam int LVL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int ADDR_W   = IDX_W + 1;
  localparam logic [DATA_W-1:0] ALL_CODE = '1;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    logic [LVL_W-1:0] lvl;
  } win_t;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int N      = 64,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [N-1:0]      mask
);
  localparam logic [DATA_W-1:0] LIM = DATA_W'(N);
  localparam logic [DATA_W-1:0] ALL = '1;

  logic is_idx, is_all;
  assign is_idx = (wdata < LIM);
  assign is_all = (wdata == ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (set_we) begin
      if (is_all)      mask <= '1;
      else if (is_idx) mask[wdata[IDX_W-1:0]] <= 1'b1;
    end else if (clr_we) begin
      if (is_all)      mask <= '0;
      else if (is_idx) mask[wdata[IDX_W-1:0]] <= 1'b0;
    end
  end

  assert_set_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wdata < LIM) |=> mask[$past(wdata[IDX_W-1:0])]);
  assert_clr_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata < LIM) |=> !mask[$past(wdata[IDX_W-1:0])]);
  assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wdata == ALL) |=> (&mask));
  assert_clr_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata == ALL) |=> (mask == '0));
  assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_we || clr_we) && wdata >= LIM && wdata != ALL) |=> $stable(mask));
endmodule

// File: rtl/intc_ctrl_file.sv
module intc_ctrl_file #(
  parameter int N      = 64,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 7,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               re,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [DATA_W-1:0]  rdata,
  output logic [N*LVL_W-1:0] levels
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(N);

  logic [DATA_W-1:0] ctrl [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ctrl[i] <= '0;
    end else if (we) begin
      ctrl[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             rdata <= '0;
    else if (re) begin
      if (raddr < LIM)      rdata <= ctrl[raddr[IDX_W-1:0]];
      else                  rdata <= '0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign levels[g*LVL_W +: LVL_W] = ctrl[g][LVL_W-1:0];
  end

  assert_rd_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (re && raddr >= LIM) |=> (rdata == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int LVL_W = 3
) (
  input  logic [N-1:0]       req,
  input  logic [N-1:0]       mask,
  input  logic [N*LVL_W-1:0] levels,
  output logic [N-1:0]       pend,
  output intc_pkg::win_t     win
);
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  assign pend = req & ~mask;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && levels[i*LVL_W +: LVL_W] > best_lvl) begin
        best_lvl = levels[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign win.valid = (best_lvl != '0);
  assign win.idx   = best_idx;
  assign win.lvl   = best_lvl;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output logic [LVL_W-1:0]  win_level
);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_SRC + 1);

  logic ctrl_we, set_we, clr_we;
  logic [NUM_SRC-1:0]       mask, pend;
  logic [NUM_SRC*LVL_W-1:0] levels;
  win_t                     win_d, win_q;

  assign ctrl_we = bus_we && (bus_addr < SET_ADDR);
  assign set_we  = bus_we && (bus_addr == SET_ADDR);
  assign clr_we  = bus_we && (bus_addr == CLR_ADDR);

  intc_mask_bank #(.N(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(bus_wdata), .mask(mask));

  intc_ctrl_file #(.N(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
                   .LVL_W(LVL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .waddr(bus_addr[IDX_W-1:0]),
    .wdata(bus_wdata), .re(bus_re), .raddr(bus_raddr), .rdata(bus_rdata),
    .levels(levels));

  intc_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_arb (
    .req(irq_req), .mask(mask), .levels(levels), .pend(pend), .win(win_d));

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win_valid = win_q.valid;
  assign win_idx   = win_q.idx;
  assign win_level = win_q.lvl;

  assert_lvl_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_level != '0));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_idx == '0 && win_level == '0));
  assert_win_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> |($past(pend) & ({{(NUM_SRC-1){1'b0}}, 1'b1} << win_idx)));
  assert_no_pend_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) == '0) |-> !win_valid);
endmodule

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [6:0]  bus_addr = '0, bus_raddr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] irq_req = '0;
  logic        win_valid;
  logic [5:0]  win_idx;
  logic [2:0]  win_level;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  bit   m_mask [64];
  logic [7:0] m_ctrl [64];

  always #2 clk = ~clk;

  irq_mask_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .win_valid(win_valid),
    .win_idx(win_idx), .win_level(win_level));

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected winner: scan levels top-down, first (lowest) index at that level.
  task automatic model_win(input logic [63:0] req, output int v, output int idx, output int lv);
    v = 0; idx = 0; lv = 0;
    for (int l = 7; l >= 1 && v == 0; l--)
      for (int i = 0; i < 64 && v == 0; i++)
        if (req[i] && !m_mask[i] && int'(m_ctrl[i][2:0]) == l) begin
          v = 1; idx = i; lv = l;
        end
  endtask

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    if (a < 7'd64) m_ctrl[a[5:0]] = d;
    else if (a == 7'd64 || a == 7'd65) begin
      if (d == 8'hFF) for (int i = 0; i < 64; i++) m_mask[i] = (a == 7'd64);
      else if (d < 8'd64) m_mask[d[5:0]] = (a == 7'd64);
    end
  endtask

  task automatic step(input logic we, input logic [6:0] a, input logic [7:0] d,
                      input logic re, input logic [6:0] ra, input logic [63:0] req,
                      input string tag);
    int ev, ei, el, er;
    bus_we = we; bus_addr = a; bus_wdata = d;
    bus_re = re; bus_raddr = ra; irq_req = req;
    model_win(req, ev, ei, el);
    er = (ra < 7'd64) ? int'(m_ctrl[ra[5:0]]) : 0;
    @(posedge clk);
    if (we) model_write(a, d);
    #1;
    chk({tag, " valid"}, int'(win_valid), ev);
    chk({tag, " idx"},   int'(win_idx),   ei);
    chk({tag, " level"}, int'(win_level), el);
    if (re) chk({tag, " rdata"}, int'(bus_rdata), er);
    @(negedge clk);
  endtask

  task automatic idle(input logic [63:0] req, input string tag);
    step(1'b0, 7'd0, 8'd0, 1'b0, 7'd0, req, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin m_mask[i] = 1'b1; m_ctrl[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    chk("R1 reset valid", int'(win_valid), 0);
    chk("R1 reset idx", int'(win_idx), 0);
    chk("R1 reset level", int'(win_level), 0);
    chk("R1 reset rdata", int'(bus_rdata), 0);
    step(1'b0, 0, 0, 1'b1, 7'd5, '1, "R1 all masked, ctrl zero");
    // R7: store and read back a full byte
    step(1'b1, 7'd3, 8'hA5, 1'b0, 0, '1, "R7 write ctrl3");
    step(1'b0, 0, 0, 1'b1, 7'd3, '1, "R7 readback ctrl3");
    step(1'b0, 0, 0, 1'b1, 7'd64, '1, "R7 read setreg zero");
    step(1'b0, 0, 0, 1'b1, 7'd100, '1, "R7 read high zero");
    // R3: unmask source 3 (level 5)
    step(1'b1, 7'd65, 8'd3, 1'b0, 0, 64'h8, "R3 clear3 issue");
    idle(64'h8, "R3 source3 wins");
    // R2: mask it again
    step(1'b1, 7'd64, 8'd3, 1'b0, 0, 64'h8, "R2 set3 issue");
    idle(64'h8, "R2 source3 masked");
    // R5: unmask all; R9 ties and priority
    step(1'b1, 7'd65, 8'hFF, 1'b0, 0, '0, "R5 clear all");
    step(1'b1, 7'd10, 8'h05, 1'b0, 0, '0, "R9 ctrl10");
    idle((64'h1 << 10) | 64'h8, "R9 tie lower index");
    step(1'b1, 7'd20, 8'h07, 1'b0, 0, '0, "R9 ctrl20");
    idle((64'h1 << 10) | (64'h1 << 20) | 64'h8, "R9 highest level");
    idle(64'h1 << 63, "R8 level0 source63");
    // R8: upper bits set, level 0
    step(1'b1, 7'd30, 8'hF8, 1'b0, 0, '0, "R8 ctrl30");
    idle(64'h1 << 30, "R8 level zero never wins");
    // R6: out-of-range codes and unused addresses ignored
    step(1'b1, 7'd64, 8'h80, 1'b0, 0, 64'h8, "R6 set 0x80");
    idle(64'h8, "R6 after set 0x80");
    step(1'b1, 7'd65, 8'h40, 1'b0, 0, 64'h8, "R6 clear 0x40");
    step(1'b1, 7'd64, 8'hFE, 1'b0, 0, 64'h8, "R6 set 0xFE");
    idle(64'h8, "R6 after set 0xFE");
    step(1'b1, 7'd70, 8'h03, 1'b0, 0, 64'h8, "R6 unused addr");
    idle(64'h8, "R6 after unused addr");
    // R4: mask all at once
    step(1'b1, 7'd64, 8'hFF, 1'b0, 0, '1, "R4 set all");
    idle('1, "R4 all masked");
    // R10: a request change shows after one edge
    step(1'b1, 7'd65, 8'hFF, 1'b0, 0, '0, "R10 clear all");
    idle(64'h8, "R10 request shows next edge");
    idle('0, "R10 request drop shows next edge");
    // Random traffic: R9 and R10 against the model
    for (int n = 0; n < 4000; n++) begin
      int op, r;
      logic [6:0] a;
      logic [7:0] d;
      logic [63:0] req;
      req = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      op = int'($urandom % 10);
      r  = int'($urandom % 8);
      d  = (r == 0) ? 8'hFF : (r == 1) ? 8'(8'h40 + $urandom % 8'hBF) : 8'($urandom % 64);
      if (op < 5)
        step(1'b1, 7'($urandom % 64), 8'($urandom), 1'b0, 0, req, "R9 rand ctrl");
      else if (op < 7)
        step(1'b1, 7'd64, d, 1'b0, 0, req, "R10 rand set");
      else if (op < 9)
        step(1'b1, 7'd65, d, 1'b0, 0, req, "R10 rand clear");
      else begin
        a = 7'($urandom % 128);
        step(1'b0, 0, 0, 1'b1, a, req, "R7 rand read");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule